// File: doc/BRIEF.md
# Multicast Copy Interval Address Generator

This block sits at the front of a multicast copy network. In each slot every input lane may present a request made of a channel number and a copy count. This replaces a header that would list every destination. The block sums the copy counts of the active lanes with a parallel-prefix adder network. Each adder cell produces the sum of its two operands, and a plain wire passes the lower operand on. Each lane's running sum becomes the first output index of its copy window. A lane is granted a contiguous window `[lo, hi]` with `hi = lo + count - 1`. It also gets a compact route index for the concentrator stage that precedes copy distribution. Inside the window each copy later takes its own distinct index.

A lane is active when its valid bit is high and its copy count is non-zero. Inactive lanes add zero to the running sum and receive nothing. The fabric has a fixed number of outputs. An active lane whose window would end past the last output is refused for the slot and flagged for retry. Results are registered, so a request presented before a clock edge appears on the outputs just after that edge.

Top module: `mcg_addr_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it, every grant and retry flag and every window, route and channel field is zero.
- R2: A lane whose valid bit is low or whose copy count is zero adds nothing to the running sum, and shows grant 0, retry 0 and all fields 0.
- R3: A granted lane shows lo equal to the sum of the copy counts of the active lanes at lower lane indices, and hi equal to lo plus its own count minus one.
- R4: The windows of granted lanes never overlap, and they ascend with lane index, so every copy of every channel gets a distinct output index.
- R5: A granted lane's route field equals the number of active lanes below it, so the granted lanes hold routes 0 to G-1 with no gaps, in lane order.
- R6: An active lane whose lo plus count exceeds the output count N_OUT shows grant 0 and retry 1, with zero window, route and channel fields.
- R7: When a lane is flagged for retry, no lane at a higher index is granted in the same slot.
- R8: A granted lane's channel field repeats the channel number its request carried.
- R9: Outputs change only at a clock edge and reflect the request present at that edge, one cycle of latency.
- R10: With N_OUT = 16 and counts 2, 3 and 5 on the three lowest lanes (other lanes idle), the windows are [0,1], [2,4] and [5,9] with routes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Per-lane request valid |
| req_chan | input | N_PORTS*CH_W | Per-lane channel number, lane i at bits [i*CH_W +: CH_W] |
| req_copies | input | N_PORTS*CNT_W | Per-lane copy count, lane i at bits [i*CNT_W +: CNT_W] |
| out_grant | output | N_PORTS | Lane received a window this slot |
| out_retry | output | N_PORTS | Active lane refused for overflow |
| out_lo | output | N_PORTS*IDX_W | First output index of the window |
| out_hi | output | N_PORTS*IDX_W | Last output index of the window |
| out_route | output | N_PORTS*RT_W | Compact concentrator route index |
| out_chan | output | N_PORTS*CH_W | Channel number of a granted lane |

## Verification
On every cycle the assertions check several properties of the outputs. Grant and retry never both show on one lane. Granted windows lie inside the fabric, ordered and disjoint across every pair of lanes. No lane above a retried lane is granted, and an idle lane never shows a grant in the next cycle. The exact window bounds, the compactness of the route indices and the point where overflow begins all depend on the counts presented. Only the bench's scenarios show these: the three-connection example, idle lanes mixed with count-zero lanes, an exact fill of the fabric, a single oversized request, and random traffic. Each is compared against a serial accumulation done lane by lane.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

   // Prefix structure used for the running sums.
   typedef enum int {
      PFX_PARALLEL = 0,   // log2(N) levels of adder cells
      PFX_RIPPLE   = 1    // one adder cell per lane in series
   } pfx_arch_e;

endpackage

// File: rtl/mcg_sum_cell.sv
// One running-sum adder cell: sum_o = x_i + y_i. The x operand is passed
// on by plain wiring where the network needs it.
module mcg_sum_cell #(
   parameter int W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum_o
);

   initial begin
      if (W < 1) $fatal(1, "mcg_sum_cell: W must be at least 1");
   end

   assign sum_o = x_i + y_i;

endmodule

// File: rtl/mcg_prefix_net.sv
// Exclusive prefix sum over LANES terms of W bits.
module mcg_prefix_net
   import mcg_pkg::*;
#(
   parameter int        LANES = 8,
   parameter int        W     = 8,
   parameter pfx_arch_e ARCH  = PFX_PARALLEL
) (
   input  logic [LANES*W-1:0] term_i,
   output logic [LANES*W-1:0] excl_o
);

   localparam int LVLS = $clog2(LANES);

   initial begin
      if (LANES < 2) $fatal(1, "mcg_prefix_net: LANES must be at least 2");
      if (W < 1)     $fatal(1, "mcg_prefix_net: W must be at least 1");
   end

   logic [W-1:0] incl [LANES];

   generate
      if (ARCH == PFX_PARALLEL) begin : g_par
         logic [W-1:0] lvl [LVLS+1][LANES];
         for (genvar i = 0; i < LANES; i++) begin : g_seed
            assign lvl[0][i] = term_i[i*W +: W];
         end
         for (genvar l = 0; l < LVLS; l++) begin : g_lvl
            for (genvar i = 0; i < LANES; i++) begin : g_lane
               if (i >= (1 << l)) begin : g_add
                  mcg_sum_cell #(.W(W)) u_cell (
                     .x_i  (lvl[l][i-(1<<l)]),
                     .y_i  (lvl[l][i]),
                     .sum_o(lvl[l+1][i])
                  );
               end else begin : g_pass
                  assign lvl[l+1][i] = lvl[l][i];
               end
            end
         end
         for (genvar i = 0; i < LANES; i++) begin : g_out
            assign incl[i] = lvl[LVLS][i];
         end
      end else begin : g_rip
         assign incl[0] = term_i[0 +: W];
         for (genvar i = 1; i < LANES; i++) begin : g_chain
            mcg_sum_cell #(.W(W)) u_cell (
               .x_i  (incl[i-1]),
               .y_i  (term_i[i*W +: W]),
               .sum_o(incl[i])
            );
         end
      end
   endgenerate

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_excl
         if (i == 0) begin : g_first
            assign excl_o[0 +: W] = '0;
         end else begin : g_rest
            assign excl_o[i*W +: W] = incl[i-1];
         end
      end
   endgenerate

endmodule

// File: rtl/mcg_lane_window.sv
// Per-lane window decision: turns the lane's running sum into a window,
// or a retry when the window would pass the last fabric output.
module mcg_lane_window #(
   parameter int N_OUT = 16,
   parameter int SUM_W = 8,
   parameter int CNT_W = 5,
   parameter int IDX_W = 4,
   parameter int RT_W  = 3,
   parameter int CH_W  = 8
) (
   input  logic             active_i,
   input  logic [SUM_W-1:0] start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [RT_W-1:0]  rank_i,
   input  logic [CH_W-1:0]  chan_i,
   output logic             grant_o,
   output logic             retry_o,
   output logic [IDX_W-1:0] lo_o,
   output logic [IDX_W-1:0] hi_o,
   output logic [RT_W-1:0]  route_o,
   output logic [CH_W-1:0]  chan_o
);

   localparam logic [SUM_W:0] LIMIT = (SUM_W+1)'(N_OUT);

   initial begin
      if (SUM_W < CNT_W) $fatal(1, "mcg_lane_window: SUM_W below CNT_W");
      if (CNT_W < IDX_W) $fatal(1, "mcg_lane_window: CNT_W below IDX_W");
   end

   logic [SUM_W:0]   end_x;
   logic             fits;
   logic [IDX_W-1:0] last;

   assign end_x = {1'b0, start_i} + {{(SUM_W+1-CNT_W){1'b0}}, count_i};
   assign fits  = (end_x <= LIMIT);
   assign last  = start_i[IDX_W-1:0] + count_i[IDX_W-1:0] - IDX_W'(1);

   always_comb begin
      grant_o = active_i & fits;
      retry_o = active_i & ~fits;
      lo_o    = grant_o ? start_i[IDX_W-1:0] : '0;
      hi_o    = grant_o ? last               : '0;
      route_o = grant_o ? rank_i             : '0;
      chan_o  = grant_o ? chan_i             : '0;
   end

endmodule

// File: rtl/mcg_addr_gen.sv
// Running-sum copy address generator (top).
module mcg_addr_gen
   import mcg_pkg::*;
#(
   parameter int        N_PORTS = 8,
   parameter int        N_OUT   = 16,
   parameter int        CH_W    = 8,
   parameter pfx_arch_e ARCH    = PFX_PARALLEL,
   localparam int       CNT_W   = $clog2(N_OUT + 1),
   localparam int       IDX_W   = $clog2(N_OUT),
   localparam int       RT_W    = $clog2(N_PORTS),
   localparam int       SUM_W   = CNT_W + RT_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_PORTS-1:0]         req_valid,
   input  logic [N_PORTS*CH_W-1:0]    req_chan,
   input  logic [N_PORTS*CNT_W-1:0]   req_copies,
   output logic [N_PORTS-1:0]         out_grant,
   output logic [N_PORTS-1:0]         out_retry,
   output logic [N_PORTS*IDX_W-1:0]   out_lo,
   output logic [N_PORTS*IDX_W-1:0]   out_hi,
   output logic [N_PORTS*RT_W-1:0]    out_route,
   output logic [N_PORTS*CH_W-1:0]    out_chan
);

   initial begin
      if (N_PORTS < 2) $fatal(1, "mcg_addr_gen: N_PORTS must be at least 2");
      if (N_OUT < 2)   $fatal(1, "mcg_addr_gen: N_OUT must be at least 2");
      if (CH_W < 1)    $fatal(1, "mcg_addr_gen: CH_W must be at least 1");
   end

   logic [N_PORTS-1:0]       act;
   logic [N_PORTS*SUM_W-1:0] cnt_terms;
   logic [N_PORTS*SUM_W-1:0] starts;
   logic [N_PORTS*RT_W-1:0]  act_terms;
   logic [N_PORTS*RT_W-1:0]  ranks;

   generate
      for (genvar i = 0; i < N_PORTS; i++) begin : g_terms
         logic [CNT_W-1:0] cnt;
         assign cnt    = req_copies[i*CNT_W +: CNT_W];
         assign act[i] = req_valid[i] & (cnt != '0);
         // Idle lanes contribute zero to both running sums.
         assign cnt_terms[i*SUM_W +: SUM_W] =
            act[i] ? {{(SUM_W-CNT_W){1'b0}}, cnt} : '0;
         assign act_terms[i*RT_W +: RT_W] = RT_W'(act[i]);
      end
   endgenerate

   mcg_prefix_net #(.LANES(N_PORTS), .W(SUM_W), .ARCH(ARCH)) u_copy_sum (
      .term_i(cnt_terms),
      .excl_o(starts)
   );

   mcg_prefix_net #(.LANES(N_PORTS), .W(RT_W), .ARCH(ARCH)) u_rank_sum (
      .term_i(act_terms),
      .excl_o(ranks)
   );

   logic [N_PORTS-1:0]       nx_grant;
   logic [N_PORTS-1:0]       nx_retry;
   logic [N_PORTS*IDX_W-1:0] nx_lo;
   logic [N_PORTS*IDX_W-1:0] nx_hi;
   logic [N_PORTS*RT_W-1:0]  nx_route;
   logic [N_PORTS*CH_W-1:0]  nx_chan;

   generate
      for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
         mcg_lane_window #(
            .N_OUT(N_OUT), .SUM_W(SUM_W), .CNT_W(CNT_W),
            .IDX_W(IDX_W), .RT_W(RT_W), .CH_W(CH_W)
         ) u_win (
            .active_i(act[i]),
            .start_i (starts[i*SUM_W +: SUM_W]),
            .count_i (req_copies[i*CNT_W +: CNT_W]),
            .rank_i  (ranks[i*RT_W +: RT_W]),
            .chan_i  (req_chan[i*CH_W +: CH_W]),
            .grant_o (nx_grant[i]),
            .retry_o (nx_retry[i]),
            .lo_o    (nx_lo[i*IDX_W +: IDX_W]),
            .hi_o    (nx_hi[i*IDX_W +: IDX_W]),
            .route_o (nx_route[i*RT_W +: RT_W]),
            .chan_o  (nx_chan[i*CH_W +: CH_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_grant <= '0;
         out_retry <= '0;
         out_lo    <= '0;
         out_hi    <= '0;
         out_route <= '0;
         out_chan  <= '0;
      end else begin
         out_grant <= nx_grant;
         out_retry <= nx_retry;
         out_lo    <= nx_lo;
         out_hi    <= nx_hi;
         out_route <= nx_route;
         out_chan  <= nx_chan;
      end
   end

   // ---------------- assertions ----------------
   a_r6_grant_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (out_grant & out_retry) == '0);

   generate
      for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
         a_r3_window_in_fabric: assert property (@(posedge clk) disable iff (!rst_n)
            out_grant[i] |-> (out_lo[i*IDX_W +: IDX_W] <= out_hi[i*IDX_W +: IDX_W])
                          && (int'(out_hi[i*IDX_W +: IDX_W]) < N_OUT));

         a_r5_route_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            out_grant[i] |-> (int'(out_route[i*RT_W +: RT_W]) <= i));

         a_r2_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] |=> !out_grant[i] && !out_retry[i]);

         for (genvar j = i + 1; j < N_PORTS; j++) begin : g_pair
            a_r4_disjoint_ordered: assert property (@(posedge clk) disable iff (!rst_n)
               (out_grant[i] && out_grant[j]) |->
                  (out_hi[i*IDX_W +: IDX_W] < out_lo[j*IDX_W +: IDX_W]));

            a_r7_no_grant_above_retry: assert property (@(posedge clk) disable iff (!rst_n)
               out_retry[i] |-> !out_grant[j]);
         end
      end
   endgenerate

endmodule

// File: tb/tb_mcg_addr_gen.sv
`timescale 1ns/1ps
module tb_mcg_addr_gen;

   localparam int NP    = 8;
   localparam int NO    = 16;
   localparam int CHW   = 8;
   localparam int CNTW  = 5;
   localparam int IDXW  = 4;
   localparam int RTW   = 3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NP-1:0]       req_valid = '0;
   logic [NP*CHW-1:0]   req_chan = '0;
   logic [NP*CNTW-1:0]  req_copies = '0;
   logic [NP-1:0]       out_grant, out_retry;
   logic [NP*IDXW-1:0]  out_lo, out_hi;
   logic [NP*RTW-1:0]   out_route;
   logic [NP*CHW-1:0]   out_chan;

   always #10 clk = ~clk;

   mcg_addr_gen #(.N_PORTS(NP), .N_OUT(NO), .CH_W(CHW)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_chan(req_chan), .req_copies(req_copies),
      .out_grant(out_grant), .out_retry(out_retry),
      .out_lo(out_lo), .out_hi(out_hi), .out_route(out_route), .out_chan(out_chan)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // stimulus per lane
   int s_v [NP];
   int s_c [NP];
   int s_ch[NP];

   // expected outputs now visible, and for the pending request
   int e_g[NP], e_r[NP], e_lo[NP], e_hi[NP], e_rt[NP], e_ch[NP];
   int p_g[NP], p_r[NP], p_lo[NP], p_hi[NP], p_rt[NP], p_ch[NP];

   task automatic chk(input string req, input string what, input int lane,
                      input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s lane %0d: actual %0d expected %0d", req, what, lane, act, exp);
      end
   endtask

   // Serial accumulation, lane by lane.
   task automatic ref_model();
      int run = 0;
      int rank = 0;
      for (int i = 0; i < NP; i++) begin
         p_g[i] = 0; p_r[i] = 0; p_lo[i] = 0; p_hi[i] = 0; p_rt[i] = 0; p_ch[i] = 0;
         if (s_v[i] != 0 && s_c[i] != 0) begin
            if (run + s_c[i] <= NO) begin
               p_g[i] = 1; p_lo[i] = run; p_hi[i] = run + s_c[i] - 1;
               p_rt[i] = rank; p_ch[i] = s_ch[i];
            end else begin
               p_r[i] = 1;
            end
            run  += s_c[i];
            rank += 1;
         end
      end
   endtask

   task automatic compare_all(input string tag_override);
      for (int i = 0; i < NP; i++) begin
         bit idle = !(s_v[i] != 0 && s_c[i] != 0);
         string tg = (tag_override != "") ? tag_override : (idle ? "R2" : "");
         chk((tg != "") ? tg : "R6", "grant", i, int'(out_grant[i]), e_g[i]);
         chk((tg != "") ? tg : "R6", "retry", i, int'(out_retry[i]), e_r[i]);
         chk((tg != "") ? tg : "R3", "lo",    i, int'(out_lo[i*IDXW +: IDXW]), e_lo[i]);
         chk((tg != "") ? tg : "R3", "hi",    i, int'(out_hi[i*IDXW +: IDXW]), e_hi[i]);
         chk((tg != "") ? tg : "R5", "route", i, int'(out_route[i*RTW +: RTW]), e_rt[i]);
         chk((tg != "") ? tg : "R8", "chan",  i, int'(out_chan[i*CHW +: CHW]), e_ch[i]);
      end
      // R4: granted windows disjoint and ascending
      for (int i = 0; i < NP; i++)
         for (int j = i + 1; j < NP; j++)
            if (out_grant[i] && out_grant[j])
               chk("R4", "order", j,
                   int'(out_hi[i*IDXW +: IDXW] < out_lo[j*IDXW +: IDXW]), 1);
      // R7: nothing granted above a retried lane
      for (int i = 0; i < NP; i++)
         if (out_retry[i])
            for (int j = i + 1; j < NP; j++)
               chk("R7", "grant_above_retry", j, int'(out_grant[j]), 0);
   endtask

   // Drive at a falling edge, confirm nothing moved before the rising
   // edge (R9), then compare after the edge.
   task automatic step(input string tag_override);
      for (int i = 0; i < NP; i++) begin
         req_valid[i] = (s_v[i] != 0);
         req_copies[i*CNTW +: CNTW] = CNTW'(s_c[i]);
         req_chan[i*CHW +: CHW] = CHW'(s_ch[i]);
      end
      ref_model();
      #1;
      for (int i = 0; i < NP; i++) begin
         chk("R9", "grant_before_edge", i, int'(out_grant[i]), e_g[i]);
         chk("R9", "lo_before_edge", i, int'(out_lo[i*IDXW +: IDXW]), e_lo[i]);
      end
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
         e_g[i] = p_g[i]; e_r[i] = p_r[i]; e_lo[i] = p_lo[i];
         e_hi[i] = p_hi[i]; e_rt[i] = p_rt[i]; e_ch[i] = p_ch[i];
      end
      compare_all(tag_override);
   endtask

   task automatic clear_stim();
      for (int i = 0; i < NP; i++) begin s_v[i] = 0; s_c[i] = 0; s_ch[i] = 0; end
   endtask

   task automatic zero_expect();
      for (int i = 0; i < NP; i++) begin
         e_g[i] = 0; e_r[i] = 0; e_lo[i] = 0; e_hi[i] = 0; e_rt[i] = 0; e_ch[i] = 0;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      clear_stim();
      zero_expect();
      // R1: reset with busy inputs, outputs stay clear
      for (int i = 0; i < NP; i++) begin s_v[i] = 1; s_c[i] = 1; s_ch[i] = i + 1; end
      for (int i = 0; i < NP; i++) begin
         req_valid[i] = 1'b1;
         req_copies[i*CNTW +: CNTW] = CNTW'(1);
         req_chan[i*CHW +: CHW] = CHW'(i + 1);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;
      clear_stim();
      req_valid = '0; req_copies = '0; req_chan = '0;
      @(posedge clk);
      @(negedge clk);
      compare_all("R1");

      // R10: counts 2,3,5 on the three lowest lanes
      clear_stim();
      s_v[0] = 1; s_c[0] = 2; s_ch[0] = 7;
      s_v[1] = 1; s_c[1] = 3; s_ch[1] = 8;
      s_v[2] = 1; s_c[2] = 5; s_ch[2] = 9;
      step("");
      chk("R10", "lo0", 0, int'(out_lo[0 +: IDXW]), 0);
      chk("R10", "hi0", 0, int'(out_hi[0 +: IDXW]), 1);
      chk("R10", "lo1", 1, int'(out_lo[IDXW +: IDXW]), 2);
      chk("R10", "hi1", 1, int'(out_hi[IDXW +: IDXW]), 4);
      chk("R10", "lo2", 2, int'(out_lo[2*IDXW +: IDXW]), 5);
      chk("R10", "hi2", 2, int'(out_hi[2*IDXW +: IDXW]), 9);
      chk("R10", "route2", 2, int'(out_route[2*RTW +: RTW]), 2);

      // R2: idle lanes (valid low with count, valid high with count 0)
      clear_stim();
      s_v[0] = 0; s_c[0] = 5; s_ch[0] = 1;
      s_v[1] = 1; s_c[1] = 4; s_ch[1] = 2;
      s_v[2] = 1; s_c[2] = 0; s_ch[2] = 3;
      s_v[3] = 1; s_c[3] = 3; s_ch[3] = 4;
      s_v[5] = 0; s_c[5] = 9; s_ch[5] = 5;
      s_v[6] = 1; s_c[6] = 2; s_ch[6] = 6;
      step("");
      chk("R2", "lo_after_idle", 1, int'(out_lo[IDXW +: IDXW]), 0);
      chk("R5", "route_compact", 6, int'(out_route[6*RTW +: RTW]), 2);

      // R6: overflow on the third request
      clear_stim();
      for (int i = 0; i < 4; i++) begin s_v[i] = 1; s_c[i] = 6; s_ch[i] = 20 + i; end
      step("");
      chk("R6", "retry_lane2", 2, int'(out_retry[2]), 1);

      // exact fill with one request of N_OUT copies
      clear_stim();
      s_v[4] = 1; s_c[4] = 16; s_ch[4] = 44;
      step("");
      chk("R3", "full_hi", 4, int'(out_hi[4*IDXW +: IDXW]), 15);

      // R6: single oversized request
      clear_stim();
      s_v[0] = 1; s_c[0] = 17; s_ch[0] = 1;
      s_v[1] = 1; s_c[1] = 1;  s_ch[1] = 2;
      step("");
      chk("R6", "oversize_retry", 0, int'(out_retry[0]), 1);

      // all lanes two copies each: exactly fills the fabric
      clear_stim();
      for (int i = 0; i < NP; i++) begin s_v[i] = 1; s_c[i] = 2; s_ch[i] = 100 + i; end
      step("");
      chk("R3", "last_hi", 7, int'(out_hi[7*IDXW +: IDXW]), 15);

      // all lanes three copies: lanes 5..7 retried
      clear_stim();
      for (int i = 0; i < NP; i++) begin s_v[i] = 1; s_c[i] = 3; s_ch[i] = 50 + i; end
      step("");
      chk("R7", "retry_lane5", 5, int'(out_retry[5]), 1);

      // random traffic
      for (int k = 0; k < 300; k++) begin
         for (int i = 0; i < NP; i++) begin
            s_v[i]  = ($urandom % 4) != 0 ? 1 : 0;
            s_c[i]  = (k % 3 == 0) ? int'($urandom % 8) : int'($urandom % 4);
            s_ch[i] = int'($urandom % 256);
         end
         step("");
      end

      // R1: reset mid-run clears outputs
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      zero_expect();
      compare_all("R1");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule